// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire (I2C-style) slave that fronts a 1024-byte storage array held in on-chip registers. SCL and SDA are sampled with the system clock. The slave pulls SDA low through an open-drain enable, and the wire itself is a wired-AND of the master and the slave. The block decodes a device address byte and a word address byte. It accepts single-byte and page writes. It serves reads from a persistent address pointer, either at the current pointer, after a dummy write that loads the pointer, or as a run of consecutive bytes.

Written bytes collect in a page buffer. They reach the array only when a stop ends a cleanly framed write. That stop starts a self-timed programming interval of `wr_cycles` clocks. During the interval the slave does not follow the bus at all, so a master detects the end of programming by repeating an address byte until it is acknowledged. A write-protect input turns the array into read-only storage while keeping the bus handshake unchanged.

The bus pins are level signals with no valid/ready handshake. The wire protocol itself paces the data, and the slave never stretches the clock.

Top module: `eep_slave`

## Requirements
- R1: After reset the slave releases SDA, the address pointer is 0 and every array byte reads as 0x00.
- R2: A device address byte is acknowledged only when its bits 7:4 equal 1010b. Bit 0 is the direction (0 write, 1 read), bits 2:1 are address bits 9:8 and bit 3 is ignored. Any other byte gets no ACK, and the slave then waits for the next start.
- R3: In a write, the device address, the word address and each data byte are all acknowledged. A data byte followed by stop is stored at {bits 2:1 of the device byte, word address}.
- R4: During a write only the low 4 address bits advance after each data byte, and the upper 6 bits stay fixed. More than 16 bytes wrap within the page, and a later byte overwrites an earlier one at the same offset.
- R5: A stop that follows at least one complete data byte starts a programming interval of `wr_cycles` clocks. During the interval no address is acknowledged. Afterwards the slave acknowledges again.
- R6: While `wp_i` is high, the device address, the word address and the data bytes are still acknowledged, but the array is left unchanged and no programming interval starts.
- R7: A read starts at the pointer, which holds the last accessed address plus one. After a write the pointer has wrapped within the page.
- R8: A write transaction carrying only a word address, followed by a repeated start and a read, returns the byte at that word address.
- R9: In a read, a master ACK makes the slave send the next byte. The pointer advances over the whole array, so it goes from 0x3FF to 0x000.
- R10: A master NACK ends the read, and the slave releases SDA. SDA drive changes only right after a falling SCL edge, a start or a stop.
- R11: A stop or start that arrives in the middle of a byte, or a start after data bytes, commits nothing and starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| wp_i | input | 1 | Write protect, 1 blocks programming |
| wr_cycles | input | CYC_W (16) | Length of the programming interval in clocks |

## Verification
Directed transactions cover single bytes, a 20-byte page write that wraps inside its page, a read that crosses 0x3FF into 0x000, a wrong device code, protected writes and transactions cut off mid-byte or by a repeated start. Each of these separates one address rule from its neighbour: wrapping within the page versus advancing across the array, and committing versus discarding. Seeded random write/read pairs then vary the page offset and the length. Reads that cover the whole page, including bytes that were not written, expose any stray or misplaced store. Acknowledge polling right after a stop shows whether a programming interval was started.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_RNXT
  } eep_st_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int SYNC_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  localparam int NOW = SYNC_W - 2;
  localparam int OLD = SYNC_W - 1;
  logic [SYNC_W-1:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_W-2:0], scl_i};
      sda_q <= {sda_q[SYNC_W-2:0], sda_i};
    end
  end

  assign sda_s     = sda_q[NOW];
  assign scl_rise  = scl_q[NOW] & ~scl_q[OLD];
  assign scl_fall  = ~scl_q[NOW] & scl_q[OLD];
  assign start_det = scl_q[NOW] & scl_q[OLD] & ~sda_q[NOW] & sda_q[OLD];
  assign stop_det  = scl_q[NOW] & scl_q[OLD] & sda_q[NOW] & ~sda_q[OLD];
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CYC_W-1:0] len,
  output logic             busy
);
  logic [CYC_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (go)           cnt <= len;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        wr,
  input  logic [PAGE_W-1:0]           off,
  input  logic [7:0]                  din,
  output logic [(1<<PAGE_W)-1:0][7:0] data_q,
  output logic [(1<<PAGE_W)-1:0]      mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (wr) begin
      data_q[off] <= din;
      mask_q[off] <= 1'b1;
    end
  end
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  parameter int CYC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             wp_i,
  input  logic [CYC_W-1:0] wr_cycles
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PB    = 1 << PAGE_W;
  localparam int BLK_W = ADDR_W - 8;

  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic wr_busy, wr_go, buf_clr, buf_wr;
  logic [PB-1:0][7:0] pb_data;
  logic [PB-1:0]      pb_mask;

  eep_st_e           st;
  logic [3:0]        bitcnt;
  logic [7:0]        rx, tx;
  logic [ADDR_W-1:0] ptr;
  logic [BLK_W-1:0]  blk;
  logic              rw;
  logic [7:0]        mem [DEPTH];

  eep_bus_sync #(.SYNC_W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  eep_wtimer #(.CYC_W(CYC_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .len(wr_cycles), .busy(wr_busy)
  );

  eep_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
    .off(ptr[PAGE_W-1:0]), .din(rx), .data_q(pb_data), .mask_q(pb_mask)
  );

  assign buf_clr = !wr_busy && (start_det || stop_det);
  assign wr_go   = !wr_busy && stop_det && (st == ST_WDAT) && (bitcnt <= 4'd1)
                   && (|pb_mask) && !wp_i;
  assign buf_wr  = !wr_busy && !start_det && !stop_det && (st == ST_WDAT)
                   && scl_fall && (bitcnt == 4'd8) && !wp_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_go) begin
      for (int i = 0; i < PB; i++)
        if (pb_mask[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pb_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      ptr    <= '0;
      blk    <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (wr_busy) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && bitcnt != 4'd8) begin
            rx     <= {rx[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (rx[7:4] == DEV_TYPE) begin
                sda_oe <= 1'b1;
                st     <= ST_DEV_ACK;
                rw     <= rx[0];
                blk    <= rx[BLK_W:1];
                if (rx[0]) begin
                  tx  <= mem[ptr];
                  ptr <= ptr + 1'b1;
                end
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADR) begin
              sda_oe <= 1'b1;
              st     <= ST_WADR_ACK;
              ptr    <= {blk, rx};
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_WDAT_ACK;
              ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            st     <= ST_RDAT;
            sda_oe <= ~tx[7];
          end else begin
            st     <= ST_WADR;
            sda_oe <= 1'b0;
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: if (scl_fall) begin
          st     <= ST_WDAT;
          sda_oe <= 1'b0;
          bitcnt <= '0;
        end
        ST_RDAT: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            st     <= ST_RACK;
            sda_oe <= 1'b0;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_s) begin
            tx  <= mem[ptr];
            ptr <= ptr + 1'b1;
            st  <= ST_RNXT;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_RNXT: if (scl_fall) begin
          st     <= ST_RDAT;
          sda_oe <= ~tx[7];
          bitcnt <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              wr_busy,
  input logic              wp_i,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic [3:0]        st,
  input logic [ADDR_W-1:0] ptr
);
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !sda_oe); // R5
  AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> !$past(wp_i)); // R6
  AST_SDA_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det)); // R10
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'(ST_WDAT_ACK) && $past(st) == 4'(ST_WDAT))
      |-> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R4
endmodule

bind eep_slave eep_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_busy(wr_busy), .wp_i(wp_i),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .st(st), .ptr(ptr)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
  localparam int Q = 5;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, wp, sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  eep_slave #(.ADDR_W(10), .PAGE_W(4), .CYC_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .wr_cycles(16'd400)
  );

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [1024];
  logic [9:0] ref_ptr;
  logic [7:0] wbuf [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dv(input logic [1:0] b, input logic rdn);
    return {4'b1010, 1'b0, b, rdn};
  endfunction

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bstop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ak);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ak = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 0; i < 8; i++) begin
      rbit(b);
      d = {d[6:0], b};
    end
    wbit(~mack);
  endtask

  task automatic wr_txn(input logic [9:0] a, input int n, input bit prot, input string req);
    logic ak;
    logic [3:0] o;
    bstart();
    wbyte(dv(a[9:8], 1'b0), ak); chk(ak, req, ak, 1);
    wbyte(a[7:0], ak);           chk(ak, req, ak, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ak); chk(ak, req, ak, 1);
      o = a[3:0] + 4'(i);
      if (!prot) ref_mem[{a[9:4], o}] = wbuf[i];
    end
    bstop();
    ref_ptr = {a[9:4], 4'(a[3:0] + 4'(n))};
  endtask

  task automatic poll(output int n);
    logic ak;
    n = 0;
    do begin
      bstart(); wbyte(dv(2'b00, 1'b0), ak); bstop(); n++;
    end while (!ak && n < 200);
  endtask

  task automatic rd_cur(input int n, input string req);
    logic ak;
    logic [7:0] d;
    bstart();
    wbyte(dv(2'b00, 1'b1), ak); chk(ak, req, ak, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      chk(d == ref_mem[ref_ptr], req, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 10'd1;
    end
    bstop();
    q();
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
  endtask

  task automatic rd_rand(input logic [9:0] a, input int n, input string req);
    logic ak;
    bstart();
    wbyte(dv(a[9:8], 1'b0), ak); chk(ak, "R8", ak, 1);
    wbyte(a[7:0], ak);           chk(ak, "R8", ak, 1);
    ref_ptr = a;
    rd_cur(n, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic ak;
    logic [9:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
    ref_ptr = '0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    q();
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rd_cur(1, "R1");

    bstart(); wbyte(8'hB0, ak); chk(!ak, "R2", ak, 0); bstop();

    wbuf[0] = 8'hA7;
    wr_txn(10'h235, 1, 0, "R3");
    poll(n); chk(n > 1, "R5", n, 2);
    rd_rand(10'h235, 1, "R3");

    for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h40 + i);
    wr_txn(10'h118, 20, 0, "R4");
    poll(n); chk(n > 1, "R5", n, 2);
    rd_rand(10'h110, 17, "R4");

    wbuf[0] = 8'h5C; wbuf[1] = 8'hC5;
    wr_txn(10'h0FE, 2, 0, "R7");
    poll(n);
    rd_cur(1, "R7");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(10'h3FE, 2, 0, "R9"); poll(n);
    wbuf[0] = 8'h33;
    wr_txn(10'h000, 1, 0, "R9"); poll(n);
    rd_rand(10'h3FE, 4, "R9");

    wp = 1'b1;
    wbuf[0] = 8'h5A;
    wr_txn(10'h050, 1, 1, "R6");
    poll(n); chk(n == 1, "R6", n, 1);
    wp = 1'b0;
    rd_rand(10'h050, 1, "R6");

    bstart(); wbyte(dv(2'b00, 1'b0), ak); wbyte(8'h60, ak);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bstop();
    poll(n); chk(n == 1, "R11", n, 1);
    rd_rand(10'h060, 1, "R11");
    bstart(); wbyte(dv(2'b00, 1'b0), ak); wbyte(8'h61, ak); wbyte(8'h77, ak);
    rd_rand(10'h061, 1, "R11");
    poll(n); chk(n == 1, "R11", n, 1);

    for (int it = 0; it < 12; it++) begin
      a = 10'($urandom % 1024);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_txn(a, n, 0, "R4");
      poll(n);
      rd_rand({a[9:4], 4'h0}, 16, "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule